// File: doc/BRIEF.md
# Machine Interrupt Enable and Pending Register Unit

This unit holds the machine-level interrupt enable and pending registers of a small 32-bit RISC-V core. It also answers reads of the read-only identification registers. Three interrupt causes are tracked:

- a timer compare level, which is shown live;
- a change on any line of a monitored input vector, which is latched;
- a one-cycle message-arrival strobe from a serial message bus, which is latched.

The core reaches the unit through a simple register port. A read is combinational from the address. A write takes effect at the clock edge.

The unit also drives a single interrupt request toward the core. The request is qualified by the global machine interrupt enable bit, which the core supplies from its status register. Trap entry and the saving of the return address and cause stay in the core.

The two latched causes are sticky. Hardware sets them, and they hold until software writes a zero into their bit of the pending register. When a hardware event and a software clear of the same bit arrive in the same cycle, the event wins, so no event is lost.

Top module: `irq_csr_unit`

## Requirements
- R1: The enable register at address 0x304 stores bit 7 (timer), bit 16 (input change) and bit 17 (message) of each write to it. A read returns those three bits, and every other bit reads zero.
- R2: Bit 7 of the pending register at address 0x344 always equals `timer_pend` in the same cycle, and software writes to that bit have no effect.
- R3: When `pin_vec` differs in any bit from its value at the previous clock edge, bit 16 of the pending register is set at the next edge. The first cycle after reset never counts as a change.
- R4: A high `msg_valid` at a clock edge sets bit 16+1 (bit 17) of the pending register at that edge.
- R5: Pending bits 16 and 17 keep their value until a write to 0x344 loads them. A write of 0 clears them and a write of 1 sets them. All other pending bits read zero.
- R6: When a hardware set and a software write of 0 hit the same pending bit in the same cycle, the bit ends up set.
- R7: `irq_req` is high in the same cycle exactly when `global_ie` is 1 and the bitwise AND of the pending and enable registers is nonzero.
- R8: The identification registers read fixed values: 0x301 reads 0x40801107, 0xF11 reads 0, 0xF12 reads 53, 0xF13 reads 0x5256436F, and 0xF14 reads the hart number parameter (default 0).
- R9: After reset the enable register and pending bits 16 and 17 are zero.
- R10: Reads of any other address return zero, and writes to any other address leave the enable and pending registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 12 | Register address for reads and writes |
| csr_wen | input | 1 | Write strobe, applied at the clock edge |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Combinational read data for `csr_addr` |
| global_ie | input | 1 | Global machine interrupt enable from the status register |
| timer_pend | input | 1 | Timer compare level |
| pin_vec | input | PIN_W | Monitored input lines |
| msg_valid | input | 1 | One-cycle message-arrival strobe |
| irq_req | output | 1 | Interrupt request toward the core |

## Verification
A corrupted enable or pending bit can be seen at two places on the same cycle it goes wrong. The read port shows it as soon as the core selects 0x304 or 0x344. `irq_req` shows it for any cause whose enable is set while `global_ie` is high.

A lost or stale input-change history shows up one edge after a toggle on `pin_vec`, as a missing or spurious bit 16. A broken set-versus-clear priority leaves bit 16 or 17 at zero on the edge where the event and the clear coincide.

The bench therefore reads the registers back after every stimulus. It also sweeps all enable, pending and global-enable combinations against `irq_req`.

// File: rtl/irq_csr_pkg.sv
package irq_csr_pkg;

    localparam logic [11:0] ADDR_MIE    = 12'h304;
    localparam logic [11:0] ADDR_MIP    = 12'h344;
    localparam logic [11:0] ADDR_ISA    = 12'h301;
    localparam logic [11:0] ADDR_VENDOR = 12'hF11;
    localparam logic [11:0] ADDR_ARCH   = 12'hF12;
    localparam logic [11:0] ADDR_IMPL   = 12'hF13;
    localparam logic [11:0] ADDR_HART   = 12'hF14;

    localparam int BIT_TMR = 7;
    localparam int BIT_PIN = 16;
    localparam int BIT_MSG = 17;

    localparam logic [31:0] ISA_VALUE    = 32'h4080_1107;
    localparam logic [31:0] VENDOR_VALUE = 32'h0000_0000;
    localparam logic [31:0] ARCH_VALUE   = 32'd53;
    localparam logic [31:0] IMPL_VALUE   = 32'h5256_436F;

    localparam logic [31:0] IRQ_MASK = (32'd1 << BIT_TMR) | (32'd1 << BIT_PIN) | (32'd1 << BIT_MSG);

    typedef struct packed {
        logic msg;
        logic pin;
        logic tmr;
    } irq_vec_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MIE,
        SEL_MIP,
        SEL_ISA,
        SEL_VENDOR,
        SEL_ARCH,
        SEL_IMPL,
        SEL_HART
    } csr_sel_e;

    function automatic logic [31:0] irq_to_word(irq_vec_t v);
        logic [31:0] w;
        w = '0;
        w[BIT_TMR] = v.tmr;
        w[BIT_PIN] = v.pin;
        w[BIT_MSG] = v.msg;
        return w;
    endfunction

    function automatic irq_vec_t word_to_irq(logic [31:0] w);
        irq_vec_t v;
        v.tmr = w[BIT_TMR];
        v.pin = w[BIT_PIN];
        v.msg = w[BIT_MSG];
        return v;
    endfunction

    function automatic csr_sel_e decode_addr(logic [11:0] a);
        case (a)
            ADDR_MIE:    return SEL_MIE;
            ADDR_MIP:    return SEL_MIP;
            ADDR_ISA:    return SEL_ISA;
            ADDR_VENDOR: return SEL_VENDOR;
            ADDR_ARCH:   return SEL_ARCH;
            ADDR_IMPL:   return SEL_IMPL;
            ADDR_HART:   return SEL_HART;
            default:     return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irq_change_detect.sv
module irq_change_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] vec_i,
    output logic         change_o
);

    logic [W-1:0] prev_q;
    logic         primed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= vec_i;
            primed_q <= 1'b1;
        end
    end

    assign change_o = primed_q && (vec_i != prev_q);

    AST_STEADY_QUIET: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $stable(vec_i)) |-> !change_o); // R3

endmodule

// File: rtl/irq_sticky_bit.sv
module irq_sticky_bit (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic wr_i,
    input  logic wd_i,
    output logic q_o
);

    logic q;

    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (set_i)
            q <= 1'b1;
        else if (wr_i)
            q <= wd_i;
    end

    assign q_o = q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (set_i && wr_i && !wd_i) |=> q_o); // R6

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!set_i && !wr_i) |=> $stable(q_o)); // R5

endmodule

// File: rtl/irq_csr_readmux.sv
module irq_csr_readmux
    import irq_csr_pkg::*;
#(
    parameter logic [31:0] HART_ID = 32'd0
) (
    input  logic [11:0] addr_i,
    input  irq_vec_t    mie_i,
    input  irq_vec_t    mip_i,
    output logic [31:0] rdata_o
);

    csr_sel_e sel;

    always_comb begin
        sel = decode_addr(addr_i);
        unique case (sel)
            SEL_MIE:    rdata_o = irq_to_word(mie_i);
            SEL_MIP:    rdata_o = irq_to_word(mip_i);
            SEL_ISA:    rdata_o = ISA_VALUE;
            SEL_VENDOR: rdata_o = VENDOR_VALUE;
            SEL_ARCH:   rdata_o = ARCH_VALUE;
            SEL_IMPL:   rdata_o = IMPL_VALUE;
            SEL_HART:   rdata_o = HART_ID;
            default:    rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irq_csr_unit.sv
module irq_csr_unit
    import irq_csr_pkg::*;
#(
    parameter int          PIN_W   = 8,
    parameter logic [31:0] HART_ID = 32'd0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [11:0]      csr_addr,
    input  logic             csr_wen,
    input  logic [31:0]      csr_wdata,
    output logic [31:0]      csr_rdata,
    input  logic             global_ie,
    input  logic             timer_pend,
    input  logic [PIN_W-1:0] pin_vec,
    input  logic             msg_valid,
    output logic             irq_req
);

    localparam int N_STICKY = 2;

    irq_vec_t mie_q;
    irq_vec_t mip_v;
    irq_vec_t wr_v;
    logic     pin_chg;
    logic     wr_mie;
    logic     wr_mip;

    logic [N_STICKY-1:0] sticky_set;
    logic [N_STICKY-1:0] sticky_wd;
    logic [N_STICKY-1:0] sticky_q;

    assign wr_v   = word_to_irq(csr_wdata);
    assign wr_mie = csr_wen && (csr_addr == ADDR_MIE);
    assign wr_mip = csr_wen && (csr_addr == ADDR_MIP);

    always_ff @(posedge clk) begin
        if (rst)
            mie_q <= '0;
        else if (wr_mie)
            mie_q <= wr_v;
    end

    irq_change_detect #(.W(PIN_W)) chg_i (
        .clk      (clk),
        .rst      (rst),
        .vec_i    (pin_vec),
        .change_o (pin_chg)
    );

    assign sticky_set = {msg_valid, pin_chg};
    assign sticky_wd  = {wr_v.msg, wr_v.pin};

    for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
        irq_sticky_bit bit_i (
            .clk   (clk),
            .rst   (rst),
            .set_i (sticky_set[g]),
            .wr_i  (wr_mip),
            .wd_i  (sticky_wd[g]),
            .q_o   (sticky_q[g])
        );
    end

    assign mip_v.tmr = timer_pend;
    assign mip_v.pin = sticky_q[0];
    assign mip_v.msg = sticky_q[1];

    assign irq_req = global_ie && ((mip_v & mie_q) != '0);

    irq_csr_readmux #(.HART_ID(HART_ID)) rd_i (
        .addr_i  (csr_addr),
        .mie_i   (mie_q),
        .mip_i   (mip_v),
        .rdata_o (csr_rdata)
    );

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((csr_addr == ADDR_MIE) || (csr_addr == ADDR_MIP)) |-> ((csr_rdata & ~IRQ_MASK) == '0)); // R1

    AST_TIMER_LIVE: assert property (@(posedge clk) disable iff (rst)
        (csr_addr == ADDR_MIP) |-> (csr_rdata[BIT_TMR] == timer_pend)); // R2

    AST_PIN_LATCH: assert property (@(posedge clk) disable iff (rst)
        pin_chg |=> mip_v.pin); // R3

    AST_MSG_LATCH: assert property (@(posedge clk) disable iff (rst)
        msg_valid |=> mip_v.msg); // R4

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        !global_ie |-> !irq_req); // R7

    AST_MIE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_mie |=> $stable(mie_q)); // R10

endmodule

// File: tb/irq_csr_unit_tb_top.sv
module irq_csr_unit_tb_top;

    localparam int PIN_W = 8;

    logic             clk = 1'b0;
    logic             rst;
    logic [11:0]      csr_addr;
    logic             csr_wen;
    logic [31:0]      csr_wdata;
    logic [31:0]      csr_rdata;
    logic             global_ie;
    logic             timer_pend;
    logic [PIN_W-1:0] pin_vec;
    logic             msg_valid;
    logic             irq_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    irq_csr_unit #(.PIN_W(PIN_W), .HART_ID(32'd0)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .csr_addr   (csr_addr),
        .csr_wen    (csr_wen),
        .csr_wdata  (csr_wdata),
        .csr_rdata  (csr_rdata),
        .global_ie  (global_ie),
        .timer_pend (timer_pend),
        .pin_vec    (pin_vec),
        .msg_valid  (msg_valid),
        .irq_req    (irq_req)
    );

    function automatic logic [31:0] id_value(int a);
        case (a)
            12'h301: return 32'h4080_1107;
            12'hF12: return 32'd53;
            12'hF13: return {8'h52, 8'h56, 8'h43, 8'h6F};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
        csr_addr = a;
        #1;
        check(tag, csr_rdata, exp);
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        csr_addr  = a;
        csr_wdata = d;
        csr_wen   = 1'b1;
        @(negedge clk);
        csr_wen   = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; csr_addr = '0; csr_wen = 1'b0; csr_wdata = '0;
        global_ie = 1'b0; timer_pend = 1'b0; pin_vec = 8'hA5; msg_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R9 reset state; R3 no change seen right after reset
        rd(12'h304, 32'h0, "R9 mie after reset");
        rd(12'h344, 32'h0, "R9/R3 mip after reset");
        check("R7 irq after reset", {31'b0, irq_req}, 32'h0);

        // R8 identification values
        rd(12'h301, 32'h4080_1107, "R8 isa");
        rd(12'hF11, 32'h0, "R8 vendor");
        rd(12'hF12, 32'd53, "R8 arch");
        rd(12'hF13, 32'h5256_436F, "R8 impl");
        rd(12'hF14, 32'h0, "R8 hart");

        // R10 full address sweep with everything cleared
        for (int a = 0; a < 4096; a++) begin
            csr_addr = a[11:0];
            #1;
            check("R10 read sweep", csr_rdata, id_value(a));
        end

        // R1 enable register masking
        wr(12'h304, 32'hFFFF_FFFF);
        rd(12'h304, 32'h0003_0080, "R1 mie all ones");
        wr(12'h304, 32'h0001_0000);
        rd(12'h304, 32'h0001_0000, "R1 mie bit16");
        wr(12'h304, 32'h0);
        rd(12'h304, 32'h0, "R1 mie clear");

        // R2 timer bit live and not writable
        timer_pend = 1'b1;
        rd(12'h344, 32'h80, "R2 timer visible");
        wr(12'h344, 32'h0);
        rd(12'h344, 32'h80, "R2 write ignored");
        timer_pend = 1'b0;
        rd(12'h344, 32'h0, "R2 timer low");
        wr(12'h344, 32'h80);
        rd(12'h344, 32'h0, "R2 write one ignored");

        // R3 each input line toggled in turn
        for (int i = 0; i < PIN_W; i++) begin
            @(negedge clk);
            pin_vec[i] = ~pin_vec[i];
            @(negedge clk);
            rd(12'h344, 32'h0001_0000, "R3 toggle sets pin bit");
            repeat (2) @(negedge clk);
            rd(12'h344, 32'h0001_0000, "R5 pin bit holds");
            wr(12'h344, 32'h0);
            rd(12'h344, 32'h0, "R5 pin bit cleared");
            repeat (2) @(negedge clk);
            rd(12'h344, 32'h0, "R3 steady input quiet");
        end

        // R4 message strobe
        @(negedge clk);
        msg_valid = 1'b1;
        @(negedge clk);
        msg_valid = 1'b0;
        rd(12'h344, 32'h0002_0000, "R4 message sets bit");
        repeat (3) @(negedge clk);
        rd(12'h344, 32'h0002_0000, "R5 message bit holds");
        wr(12'h344, 32'h0002_0000);
        rd(12'h344, 32'h0002_0000, "R5 write one keeps");
        wr(12'h344, 32'h0);
        rd(12'h344, 32'h0, "R5 write zero clears");
        wr(12'h344, 32'hFFFF_FFFF);
        rd(12'h344, 32'h0003_0000, "R5 software set");
        wr(12'h344, 32'h0);

        // R6 set beats clear in same cycle
        @(negedge clk);
        csr_addr = 12'h344; csr_wdata = 32'h0; csr_wen = 1'b1; msg_valid = 1'b1;
        @(negedge clk);
        csr_wen = 1'b0; msg_valid = 1'b0;
        rd(12'h344, 32'h0002_0000, "R6 message beats clear");
        wr(12'h344, 32'h0);
        @(negedge clk);
        csr_addr = 12'h344; csr_wdata = 32'h0; csr_wen = 1'b1; pin_vec[0] = ~pin_vec[0];
        @(negedge clk);
        csr_wen = 1'b0;
        rd(12'h344, 32'h0001_0000, "R6 pin change beats clear");
        wr(12'h344, 32'h0);

        // R10 writes elsewhere have no effect
        wr(12'h305, 32'hFFFF_FFFF);
        wr(12'h300, 32'hFFFF_FFFF);
        wr(12'hF11, 32'hFFFF_FFFF);
        rd(12'h304, 32'h0, "R10 mie untouched");
        rd(12'h344, 32'h0, "R10 mip untouched");
        rd(12'hF11, 32'h0, "R10 id untouched");

        // R7 exhaustive enable x pending x global enable sweep
        for (int en = 0; en < 8; en++) begin
            for (int pd = 0; pd < 8; pd++) begin
                for (int g = 0; g < 2; g++) begin
                    wr(12'h304, {14'b0, en[2], en[1], 8'b0, en[0], 7'b0});
                    wr(12'h344, {14'b0, pd[2], pd[1], 16'b0});
                    timer_pend = pd[0];
                    global_ie  = g[0];
                    rd(12'h344, {14'b0, pd[2], pd[1], 8'b0, pd[0], 7'b0}, "R5 sweep pending readback");
                    check("R7 irq sweep", {31'b0, irq_req},
                          {31'b0, (g == 1) && ((en & pd) != 0)});
                end
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule